// File: doc/BRIEF.md
# Serial Character Receiver with Receive Queue and Error Interrupts

This block takes an asynchronous serial line and turns its frames into characters in a receive queue. It is fed with a strobe at sixteen times the bit rate. On a falling edge it confirms the start bit at the middle of that bit. It then samples each data bit at its centre, least significant bit first, followed by an optional parity bit and one or two stop bits. When the first stop bit has been taken, it checks the frame. That check decides whether the character goes into the queue and which status flags are set.

Parity and framing faults are recorded but do not stop reception of later characters. A pending overrun, or a pending break, blocks any further writes into the queue until software clears that flag. Three interrupt request lines are formed from the status flags and two enable inputs: data available, receive error, and break/overrun. The host drains the queue through a read strobe, and the read port is registered. Each sticky flag has its own clear strobe.

Top module: `serial_rx_core`

## Requirements
- R1: After a falling edge on the line, the start bit is sampled at its middle (8 oversampling ticks in). If the line reads high there, the edge is treated as a glitch and no character, flag or level change results.
- R2: Data bits are assembled least significant bit first. With `cfg_len8`=1, eight bits are received. With `cfg_len8`=0, seven bits are received and bit 7 of the stored character reads 0.
- R3: With `cfg_par_en`=1, one parity bit follows the data. Parity is even when `cfg_par_odd`=0 and odd when it is 1. A mismatch sets `st_parity` and `st_error`, and the character is still stored.
- R4: Only the first stop bit is checked. A low first stop bit sets `st_frame` and `st_error`, and the character is still stored. With `cfg_two_stop`=1, a low second stop bit raises no flag.
- R5: Characters leave the queue in arrival order. `fifo_level` counts the stored characters and is 0 after reset. A one-cycle `rd_en` pulse presents the head character on `rd_data` on the next clock and lowers the level by one.
- R6: A character that completes while the queue is full is discarded and sets `st_overrun`. While `st_overrun` is 1, no character is stored, even if space becomes free.
- R7: A frame that is entirely low (data, any parity bit and the first stop bit) sets `st_break` and is not stored. While `st_break` is 1, no character is stored.
- R8: `st_ready` is 1 when `fifo_level` is nonzero. `st_thresh` is 1 when `fifo_level` is at least `thr_level`.
- R9: `irq_data` is asserted when `ie_data` is 1 and either `st_ready` or `st_thresh` is 1.
- R10: `irq_error` is asserted when `st_error` is 1 and either `ie_data` or `ie_error` is 1.
- R11: `irq_break` is asserted when `st_break` or `st_overrun` is 1 and either `ie_data` or `ie_error` is 1.
- R12: `clr_err` clears `st_parity`, `st_frame` and `st_error`. `clr_brk` clears `st_break`. `clr_ovr` clears `st_overrun`. If a new event arrives in the same cycle as its clear, the event wins.
- R13: While `rx_en` is 0, the line is ignored and no character or flag results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| os_tick | input | 1 | Strobe at 16x the bit rate |
| rxd | input | 1 | Serial line, idle high |
| rx_en | input | 1 | Receiver enable |
| cfg_len8 | input | 1 | 1: eight data bits, 0: seven |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | 1: odd parity, 0: even |
| cfg_two_stop | input | 1 | Two stop bits |
| ie_data | input | 1 | Data interrupt enable (also enables the error and break lines) |
| ie_error | input | 1 | Error interrupt enable |
| thr_level | input | LVL_W | Queue threshold for `st_thresh` |
| rd_en | input | 1 | Pop the head of the queue |
| clr_err | input | 1 | Clear parity, frame and error flags |
| clr_brk | input | 1 | Clear break flag |
| clr_ovr | input | 1 | Clear overrun flag |
| rd_data | output | 8 | Character popped by the last `rd_en` |
| fifo_level | output | LVL_W | Characters in the queue |
| st_ready | output | 1 | Queue not empty |
| st_thresh | output | 1 | Level at or above threshold |
| st_parity | output | 1 | Sticky parity error |
| st_frame | output | 1 | Sticky framing error |
| st_error | output | 1 | Sticky receive error |
| st_break | output | 1 | Sticky break |
| st_overrun | output | 1 | Sticky overrun |
| irq_data | output | 1 | Data interrupt request |
| irq_error | output | 1 | Receive error interrupt request |
| irq_break | output | 1 | Break/overrun interrupt request |

## Verification
The line passes two synchronizer stages. The stop bit is judged about ten clocks into that bit. The queue write and the parity, frame, break and overrun flags follow one clock after that judgement. `st_ready` and `st_thresh` follow the level by one clock, and each interrupt line follows its flags by one more. The bench holds every frame's last bit for its full 16 clocks and then leaves 20 idle clocks before sampling, which is well past the three-clock tail. After a read pulse or a clear strobe it waits three clocks, enough for the level, the derived flags and the interrupt lines to settle. Read data is sampled on the falling edge that follows the clock which took `rd_en`.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;
  localparam int CHAR_W = 8;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_PARITY,
    RX_STOP,
    RX_STOP2,
    RX_WAIT_HIGH
  } rx_state_e;

  typedef struct packed {
    logic [CHAR_W-1:0] data;
    logic              par_bad;
    logic              stop_bad;
    logic              all_low;
  } rx_char_t;
endpackage

// File: rtl/serial_rx_sync.sv
module serial_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] pipe_q;

  always_ff @(posedge clk) begin
    if (rst) pipe_q <= '1;
    else     pipe_q <= {pipe_q[STAGES-2:0], din};
  end

  assign dout = pipe_q[STAGES-1];
endmodule

// File: rtl/serial_rx_frame.sv
module serial_rx_frame
  import serial_rx_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     tick,
  input  logic     line,
  input  logic     enable,
  input  logic     len8,
  input  logic     par_en,
  input  logic     par_odd,
  input  logic     two_stop,
  output logic     done,
  output rx_char_t chr
);
  localparam int CW = $clog2(OSR);
  localparam int BW = $clog2(CHAR_W);
  localparam logic [CW-1:0] MID_C  = CW'(OSR / 2 - 1);
  localparam logic [CW-1:0] LAST_C = CW'(OSR - 1);

  rx_state_e         state_q;
  logic [CW-1:0]     tick_cnt_q;
  logic [BW-1:0]     bit_idx_q;
  logic [CHAR_W-1:0] shift_q;
  logic              par_bit_q;
  logic [BW-1:0]     last_idx;
  logic              at_last;

  assign last_idx = len8 ? BW'(CHAR_W - 1) : BW'(CHAR_W - 2);
  assign at_last  = (tick_cnt_q == LAST_C);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= RX_IDLE;
      tick_cnt_q <= '0;
      bit_idx_q  <= '0;
      shift_q    <= '0;
      par_bit_q  <= 1'b0;
      done       <= 1'b0;
      chr        <= '0;
    end else begin
      done <= 1'b0;
      if (!enable) begin
        state_q <= RX_IDLE;
      end else if (tick) begin
        tick_cnt_q <= tick_cnt_q + 1'b1;
        unique case (state_q)
          RX_IDLE: begin
            if (!line) begin
              state_q    <= RX_START;
              tick_cnt_q <= '0;
            end
          end
          RX_START: begin
            if (tick_cnt_q == MID_C) begin
              tick_cnt_q <= '0;
              if (line) begin
                state_q <= RX_IDLE;
              end else begin
                state_q   <= RX_DATA;
                bit_idx_q <= '0;
                shift_q   <= '0;
                par_bit_q <= 1'b0;
              end
            end
          end
          RX_DATA: begin
            if (at_last) begin
              shift_q[bit_idx_q] <= line;
              if (bit_idx_q == last_idx) state_q <= par_en ? RX_PARITY : RX_STOP;
              else                       bit_idx_q <= bit_idx_q + 1'b1;
            end
          end
          RX_PARITY: begin
            if (at_last) begin
              par_bit_q <= line;
              state_q   <= RX_STOP;
            end
          end
          RX_STOP: begin
            if (at_last) begin
              done         <= 1'b1;
              chr.data     <= shift_q;
              chr.par_bad  <= par_en && ((^shift_q ^ par_bit_q) != par_odd);
              chr.stop_bad <= !line;
              chr.all_low  <= (shift_q == '0) && !line && !(par_en && par_bit_q);
              state_q      <= (two_stop && line) ? RX_STOP2 : RX_WAIT_HIGH;
            end
          end
          RX_STOP2: begin
            if (at_last) state_q <= RX_WAIT_HIGH;
          end
          RX_WAIT_HIGH: begin
            if (line) state_q <= RX_IDLE;
          end
          default: state_q <= RX_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/serial_rx_fifo.sv
module serial_rx_fifo #(
  parameter  int DW    = 8,
  parameter  int DEPTH = 16,
  localparam int LW    = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  output logic [LW-1:0] level,
  output logic          full
);
  localparam int AW = $clog2(DEPTH);

  // Pointers wrap naturally, so DEPTH is expected to be a power of two.
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wptr_q, rptr_q;
  logic          wr_ok, rd_ok;

  assign full  = (level == LW'(DEPTH));
  assign wr_ok = wr_en && !full;
  assign rd_ok = rd_en && (level != '0);

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wptr_q] <= wr_data;
    if (rd_ok) rd_data     <= mem[rptr_q];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr_q <= '0;
      rptr_q <= '0;
      level  <= '0;
    end else begin
      if (wr_ok) wptr_q <= wptr_q + 1'b1;
      if (rd_ok) rptr_q <= rptr_q + 1'b1;
      unique case ({wr_ok, rd_ok})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end
endmodule

// File: rtl/serial_rx_core.sv
module serial_rx_core
  import serial_rx_pkg::*;
#(
  parameter  int OSR    = 16,
  parameter  int DEPTH  = 16,
  parameter  int STAGES = 2,
  localparam int LVL_W  = $clog2(DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              os_tick,
  input  logic              rxd,
  input  logic              rx_en,
  input  logic              cfg_len8,
  input  logic              cfg_par_en,
  input  logic              cfg_par_odd,
  input  logic              cfg_two_stop,
  input  logic              ie_data,
  input  logic              ie_error,
  input  logic [LVL_W-1:0]  thr_level,
  input  logic              rd_en,
  input  logic              clr_err,
  input  logic              clr_brk,
  input  logic              clr_ovr,
  output logic [CHAR_W-1:0] rd_data,
  output logic [LVL_W-1:0]  fifo_level,
  output logic              st_ready,
  output logic              st_thresh,
  output logic              st_parity,
  output logic              st_frame,
  output logic              st_error,
  output logic              st_break,
  output logic              st_overrun,
  output logic              irq_data,
  output logic              irq_error,
  output logic              irq_break
);
  logic     line_s;
  logic     frame_done;
  rx_char_t frame_chr;
  logic     q_full;
  logic     store;

  serial_rx_sync #(.STAGES(STAGES)) sync_i (
    .clk (clk),
    .rst (rst),
    .din (rxd),
    .dout(line_s)
  );

  serial_rx_frame #(.OSR(OSR)) frame_i (
    .clk     (clk),
    .rst     (rst),
    .tick    (os_tick),
    .line    (line_s),
    .enable  (rx_en),
    .len8    (cfg_len8),
    .par_en  (cfg_par_en),
    .par_odd (cfg_par_odd),
    .two_stop(cfg_two_stop),
    .done    (frame_done),
    .chr     (frame_chr)
  );

  // A finished character is stored only if the queue has room and
  // neither a pending overrun nor a pending break is blocking writes.
  assign store = frame_done && !frame_chr.all_low && !q_full && !st_overrun && !st_break;

  serial_rx_fifo #(.DW(CHAR_W), .DEPTH(DEPTH)) fifo_i (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (store),
    .wr_data(frame_chr.data),
    .rd_en  (rd_en),
    .rd_data(rd_data),
    .level  (fifo_level),
    .full   (q_full)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_parity  <= 1'b0;
      st_frame   <= 1'b0;
      st_error   <= 1'b0;
      st_break   <= 1'b0;
      st_overrun <= 1'b0;
      st_ready   <= 1'b0;
      st_thresh  <= 1'b0;
      irq_data   <= 1'b0;
      irq_error  <= 1'b0;
      irq_break  <= 1'b0;
    end else begin
      if (frame_done && frame_chr.par_bad) st_parity <= 1'b1;
      else if (clr_err)                    st_parity <= 1'b0;

      if (frame_done && frame_chr.stop_bad) st_frame <= 1'b1;
      else if (clr_err)                     st_frame <= 1'b0;

      if (frame_done && (frame_chr.par_bad || frame_chr.stop_bad)) st_error <= 1'b1;
      else if (clr_err)                                            st_error <= 1'b0;

      if (frame_done && frame_chr.all_low) st_break <= 1'b1;
      else if (clr_brk)                    st_break <= 1'b0;

      if (frame_done && !frame_chr.all_low && q_full) st_overrun <= 1'b1;
      else if (clr_ovr)                               st_overrun <= 1'b0;

      st_ready  <= (fifo_level != '0);
      st_thresh <= (fifo_level >= thr_level);

      irq_data  <= ie_data && (st_ready || st_thresh);
      irq_error <= (ie_data || ie_error) && st_error;
      irq_break <= (ie_data || ie_error) && (st_break || st_overrun);
    end
  end
endmodule

// File: rtl/serial_rx_core_chk.sv
module serial_rx_core_chk #(
  parameter int DEPTH = 16,
  parameter int LVL_W = 5
) (
  input logic             clk,
  input logic             rst,
  input logic             rd_en,
  input logic             ie_data,
  input logic             ie_error,
  input logic [LVL_W-1:0] fifo_level,
  input logic             st_ready,
  input logic             st_thresh,
  input logic             st_error,
  input logic             st_break,
  input logic             st_overrun,
  input logic             irq_data,
  input logic             irq_error,
  input logic             irq_break
);
  a_r5_level_bound: assert property (@(posedge clk) disable iff (rst)
    fifo_level <= LVL_W'(DEPTH));

  a_r5_level_step: assert property (@(posedge clk) disable iff (rst)
    {1'b0, fifo_level} <= {1'b0, $past(fifo_level)} + 1'b1);

  a_r6_overrun_blocks: assert property (@(posedge clk) disable iff (rst)
    ($past(st_overrun) && !$past(rd_en)) |-> fifo_level <= $past(fifo_level));

  a_r7_break_blocks: assert property (@(posedge clk) disable iff (rst)
    ($past(st_break) && !$past(rd_en)) |-> fifo_level <= $past(fifo_level));

  a_r9_data_irq: assert property (@(posedge clk) disable iff (rst)
    irq_data |-> $past(ie_data) && ($past(st_ready) || $past(st_thresh)));

  a_r10_error_irq: assert property (@(posedge clk) disable iff (rst)
    irq_error |-> $past(st_error) && ($past(ie_data) || $past(ie_error)));

  a_r11_break_irq: assert property (@(posedge clk) disable iff (rst)
    irq_break |-> ($past(st_break) || $past(st_overrun)) && ($past(ie_data) || $past(ie_error)));
endmodule

bind serial_rx_core serial_rx_core_chk #(.DEPTH(DEPTH), .LVL_W(LVL_W)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .rd_en     (rd_en),
  .ie_data   (ie_data),
  .ie_error  (ie_error),
  .fifo_level(fifo_level),
  .st_ready  (st_ready),
  .st_thresh (st_thresh),
  .st_error  (st_error),
  .st_break  (st_break),
  .st_overrun(st_overrun),
  .irq_data  (irq_data),
  .irq_error (irq_error),
  .irq_break (irq_break)
);

// File: tb/serial_rx_core_tb_top.sv
module serial_rx_core_tb_top;
  localparam int DEPTH = 4;
  localparam int LW    = $clog2(DEPTH) + 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic os_tick = 1'b1;
  logic rxd = 1'b1;
  logic rx_en = 1'b1;
  logic cfg_len8 = 1'b1, cfg_par_en = 1'b0, cfg_par_odd = 1'b0, cfg_two_stop = 1'b0;
  logic ie_data = 1'b0, ie_error = 1'b0;
  logic [LW-1:0] thr_level = LW'(3);
  logic rd_en = 1'b0, clr_err = 1'b0, clr_brk = 1'b0, clr_ovr = 1'b0;
  logic [7:0] rd_data;
  logic [LW-1:0] fifo_level;
  logic st_ready, st_thresh, st_parity, st_frame, st_error, st_break, st_overrun;
  logic irq_data, irq_error, irq_break;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  serial_rx_core #(.OSR(16), .DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst(rst), .os_tick(os_tick), .rxd(rxd), .rx_en(rx_en),
    .cfg_len8(cfg_len8), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
    .cfg_two_stop(cfg_two_stop), .ie_data(ie_data), .ie_error(ie_error),
    .thr_level(thr_level), .rd_en(rd_en), .clr_err(clr_err), .clr_brk(clr_brk),
    .clr_ovr(clr_ovr), .rd_data(rd_data), .fifo_level(fifo_level),
    .st_ready(st_ready), .st_thresh(st_thresh), .st_parity(st_parity),
    .st_frame(st_frame), .st_error(st_error), .st_break(st_break),
    .st_overrun(st_overrun), .irq_data(irq_data), .irq_error(irq_error),
    .irq_break(irq_break)
  );

  // Fields: {stop2, stop1, flip_parity, two_stop, par_odd, par_en, len8, data}
  localparam logic [14:0] VEC [7] = '{
    {1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'hA5},
    {1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 8'h3C},
    {1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 8'h3C},
    {1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 8'hD3},
    {1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 8'h81},
    {1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'h7E},
    {1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 8'h01}
  };

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic put_bit(input logic v);
    rxd = v;
    idle(16);
  endtask

  task automatic send(input logic [7:0] d, input logic flip, input logic s1, input logic s2);
    logic [7:0] dm;
    logic p;
    dm = cfg_len8 ? d : {1'b0, d[6:0]};
    p  = (^dm) ^ cfg_par_odd ^ flip;
    put_bit(1'b0);
    for (int i = 0; i < (cfg_len8 ? 8 : 7); i++) put_bit(d[i]);
    if (cfg_par_en) put_bit(p);
    put_bit(s1);
    if (cfg_two_stop) put_bit(s2);
    rxd = 1'b1;
    idle(20);
  endtask

  task automatic send_ok(input logic [7:0] d);
    send(d, 1'b0, 1'b1, 1'b1);
  endtask

  task automatic pop(output logic [7:0] d);
    @(negedge clk) rd_en = 1'b1;
    @(negedge clk) rd_en = 1'b0;
    d = rd_data;
    idle(3);
  endtask

  task automatic pulse_clear(input int which);
    @(negedge clk);
    clr_err = (which == 0);
    clr_brk = (which == 1);
    clr_ovr = (which == 2);
    @(negedge clk);
    clr_err = 1'b0; clr_brk = 1'b0; clr_ovr = 1'b0;
    idle(3);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] got;
    logic [14:0] v;
    logic [7:0] exp_d;
    logic exp_per, exp_fer;

    idle(5);
    rst = 1'b0;
    idle(3);
    // R5 reset state
    chk("R5", "reset level", fifo_level, 0);
    chk("R8", "reset ready", st_ready, 0);
    chk("R12", "reset flags", {st_parity, st_frame, st_error, st_break, st_overrun}, 0);
    chk("R9", "reset irqs", {irq_data, irq_error, irq_break}, 0);

    // R1 short low pulse is a glitch
    @(negedge clk) rxd = 1'b0;
    idle(4);
    rxd = 1'b1;
    idle(40);
    chk("R1", "glitch level", fifo_level, 0);
    chk("R1", "glitch flags", {st_frame, st_error, st_break}, 0);

    // R13 disabled receiver ignores a frame
    rx_en = 1'b0;
    send_ok(8'h42);
    chk("R13", "disabled level", fifo_level, 0);
    chk("R13", "disabled flags", {st_error, st_break, st_overrun}, 0);
    rx_en = 1'b1;

    // Vector table: formats, parity, stop bit checks (R2 R3 R4 R10)
    ie_data = 1'b0;
    ie_error = 1'b1;
    for (int i = 0; i < 7; i++) begin
      v = VEC[i];
      cfg_len8 = v[8]; cfg_par_en = v[9]; cfg_par_odd = v[10]; cfg_two_stop = v[11];
      send(v[7:0], v[12], v[13], v[14]);
      exp_d   = v[8] ? v[7:0] : {1'b0, v[6:0]};
      exp_per = v[9] & v[12];
      exp_fer = !v[13];
      chk("R2", "vector level", fifo_level, 1);
      chk("R3", "vector parity flag", st_parity, exp_per);
      chk("R4", "vector frame flag", st_frame, exp_fer);
      chk("R10", "vector error irq", irq_error, exp_per | exp_fer);
      chk("R9", "vector data irq disabled", irq_data, 0);
      pop(got);
      chk("R2", "vector data", got, exp_d);
      pulse_clear(0);
      chk("R12", "error cleared", {st_parity, st_frame, st_error, irq_error}, 0);
    end

    // Threshold, data irq, overrun (R6 R8 R9 R11)
    cfg_len8 = 1'b1; cfg_par_en = 1'b0; cfg_par_odd = 1'b0; cfg_two_stop = 1'b0;
    ie_data = 1'b1;
    ie_error = 1'b0;
    send_ok(8'h11);
    chk("R8", "ready after one", {st_ready, st_thresh}, 2'b10);
    chk("R9", "data irq", irq_data, 1);
    send_ok(8'h12);
    send_ok(8'h13);
    chk("R8", "threshold reached", st_thresh, 1);
    send_ok(8'h14);
    chk("R5", "queue full", fifo_level, 4);
    send_ok(8'h15);
    chk("R6", "overrun flag", st_overrun, 1);
    chk("R6", "overrun level", fifo_level, 4);
    chk("R11", "break irq on overrun", irq_break, 1);
    pop(got);
    chk("R5", "first out", got, 8'h11);
    send_ok(8'h16);
    chk("R6", "blocked while overrun", fifo_level, 3);
    pulse_clear(2);
    chk("R12", "overrun cleared", {st_overrun, irq_break}, 0);
    send_ok(8'h17);
    chk("R6", "stored after clear", fifo_level, 4);
    pop(got); chk("R5", "order 2", got, 8'h12);
    pop(got); chk("R5", "order 3", got, 8'h13);
    pop(got); chk("R5", "order 4", got, 8'h14);
    pop(got); chk("R5", "order 5", got, 8'h17);
    chk("R8", "empty ready", st_ready, 0);
    chk("R9", "empty data irq", irq_data, 0);

    // Break (R7 R11)
    ie_data = 1'b0;
    ie_error = 1'b1;
    send(8'h00, 1'b0, 1'b0, 1'b1);
    chk("R7", "break flag", st_break, 1);
    chk("R7", "break not stored", fifo_level, 0);
    chk("R11", "break irq", irq_break, 1);
    send_ok(8'h55);
    chk("R7", "blocked while break", fifo_level, 0);
    pulse_clear(1);
    pulse_clear(0);
    chk("R12", "break cleared", {st_break, st_error, irq_break}, 0);
    send_ok(8'h66);
    chk("R7", "stored after break clear", fifo_level, 1);
    pop(got);
    chk("R7", "data after break", got, 8'h66);

    // Reset in the middle of traffic (R5)
    send_ok(8'h77);
    @(negedge clk) rst = 1'b1;
    idle(2);
    rst = 1'b0;
    idle(3);
    chk("R5", "level after reset", fifo_level, 0);
    chk("R8", "ready after reset", st_ready, 0);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule